// File: doc/BRIEF.md
# Golden-Ratio Stepped Tick Generator

This block runs from a fast reference clock and produces a one-cycle clock-enable pulse, `tick`. The spacing between pulses is not fixed. It grows step by step through a repeating phrase. The spacing for step k is a programmable base count multiplied by the k-th term of the integer sequence 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233. Each term is a Fibonacci number, so the ratio between neighbouring spacings approaches the golden ratio. Step 0 always has the shortest spacing, so the highest tick rate is the base rate.

When the longest step of the phrase has elapsed, the generator goes back to step 0 and the phrase repeats. An external controller can change the phrase length (8 to 12 steps) and the base count at any time. A new value only takes effect at a phrase boundary. Downstream logic uses `tick` as a clock enable. It uses `stepIdx` and `phraseStart` to follow where it is in the phrase.

Top module: `fib_tick_gen`

## Requirements
- R1: While `rstN` is low, `tick` and `phraseStart` are 0 and `stepIdx` is 0.
- R2: The interval of step k, counted in reference cycles from the previous tick (or from the `phraseStart` pulse of a new phrase) to the tick that ends it, equals base × F(k). F is 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233 for k = 0..11.
- R3: A tick that does not end a phrase lasts exactly one reference cycle.
- R4: `stepIdx` rises by one at each tick that does not end the phrase. The tick that ends the last step returns `stepIdx` to 0.
- R5: A phrase-length request below 8 acts as 8, and a request above 12 acts as 12, so a phrase holds 8 to 12 ticks.
- R6: `baseCount` and `phraseLen` are sampled only when a phrase begins. Changes made inside a phrase do not alter the remaining intervals of that phrase.
- R7: A base count of 0 acts as 1.
- R8: While `en` is low, no tick or `phraseStart` is produced and `stepIdx` holds its value. The first rising clock edge with `en` high starts a fresh phrase: `phraseStart` is high and `stepIdx` is 0 in the following cycle, and the full step-0 interval follows.
- R9: `phraseStart` is high for one cycle when a phrase begins. This is either the cycle after a start from idle, or the same cycle as the tick that ends the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable. Low holds the generator idle |
| baseCount | input | BASE_W | Base interval in reference cycles (0 acts as 1) |
| phraseLen | input | STEP_W | Requested steps per phrase, clamped to 8..12 |
| tick | output | 1 | One-cycle enable at the end of each interval |
| stepIdx | output | STEP_W | Index of the interval now in progress |
| phraseStart | output | 1 | One-cycle marker for the start of a phrase |

## Verification
After a start from idle, `phraseStart` is due one cycle after the first enabled rising edge, and the first tick comes base × F(0) cycles after that. Every later tick comes base × F(k) cycles after the one before it. `stepIdx` changes in the same cycle as each tick. The bench drives its inputs on falling edges. A behavioural model counts elapsed cycles on every rising edge, and all outputs are compared with the model on the following falling edge. Directed checks measure gaps between ticks by counting falling edges, so each measurement lands in the cycle where the registered output is due.

// File: rtl/fib_tick_pkg.sv
package fib_tick_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // k-th term of 1, 2, 3, 5, 8, ...
  function automatic int fibTerm(input int k);
    int a;
    int b;
    int t;
    a = 1;
    b = 2;
    for (int i = 0; i < k; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // bits needed to hold value v
  function automatic int bitsFor(input int v);
    int n;
    n = 1;
    while ((1 << n) <= v) n++;
    return n;
  endfunction

  typedef struct packed {
    logic loadBase;      // latch base count for a new phrase
    logic loadInterval;  // load counter with interval of nextStep
    logic countDown;     // decrement running interval
  } tickStrobes_t;
endpackage

// File: rtl/fib_interval_rom.sv
module fib_interval_rom import fib_tick_pkg::*; #(
  parameter int STEPS  = 12,
  parameter int STEP_W = 4,
  parameter int FIB_W  = 8
) (
  input  logic [STEP_W-1:0] stepSel,
  output logic [FIB_W-1:0]  fibVal
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 1 << STEP_W;

  logic [FIB_W-1:0] romVal [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gRom
    if (g < STEPS) begin : gUsed
      assign romVal[g] = FIB_W'(fibTerm(g));
    end else begin : gSpare
      assign romVal[g] = '0;
    end
  end

  assign fibVal = romVal[stepSel];
endmodule

// File: rtl/fib_tick_dp.sv
module fib_tick_dp import fib_tick_pkg::*; #(
  parameter int BASE_W = 8,
  parameter int STEPS  = 12,
  parameter int STEP_W = 4,
  parameter int FIB_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strb,
  input  logic [STEP_W-1:0] nextStep,
  input  logic [BASE_W-1:0] baseIn,
  output logic              intervalDone
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [BASE_W-1:0] effBase;
  logic [BASE_W-1:0] shadowBase;
  logic [BASE_W-1:0] useBase;
  logic [FIB_W-1:0]  fibVal;
  logic [CNT_W-1:0]  interval;
  logic [CNT_W-1:0]  remain;

  assign effBase = (baseIn == '0) ? BASE_W'(1) : baseIn;
  assign useBase = strb.loadBase ? effBase : shadowBase;

  fib_interval_rom #(
    .STEPS (STEPS),
    .STEP_W(STEP_W),
    .FIB_W (FIB_W)
  ) uRom (
    .stepSel(nextStep),
    .fibVal (fibVal)
  );

  assign interval = CNT_W'(useBase) * CNT_W'(fibVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowBase <= BASE_W'(1);
      remain     <= '0;
    end else begin
      if (strb.loadBase) shadowBase <= effBase;
      if (strb.loadInterval) remain <= interval;
      else if (strb.countDown) remain <= remain - CNT_W'(1);
    end
  end

  assign intervalDone = (remain == CNT_W'(1));
endmodule

// File: rtl/fib_tick_ctrl.sv
module fib_tick_ctrl import fib_tick_pkg::*; #(
  parameter int STEP_MIN = 8,
  parameter int STEP_MAX = 12,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [STEP_W-1:0] lenIn,
  input  logic              intervalDone,
  output tickStrobes_t      strb,
  output logic [STEP_W-1:0] nextStep,
  output logic [STEP_W-1:0] stepIdx,
  output logic              tick,
  output logic              phraseStart
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              running;
  logic [STEP_W-1:0] shadowLen;
  logic [STEP_W-1:0] lenReq;
  logic              startEv;
  logic              endEv;
  logic              wrapEv;
  logic              newPhrase;

  always_comb begin
    if (lenIn < STEP_W'(STEP_MIN))      lenReq = STEP_W'(STEP_MIN);
    else if (lenIn > STEP_W'(STEP_MAX)) lenReq = STEP_W'(STEP_MAX);
    else                                lenReq = lenIn;
  end

  assign startEv   = en && !running;
  assign endEv     = en && running && intervalDone;
  assign wrapEv    = endEv && (stepIdx == shadowLen - STEP_W'(1));
  assign newPhrase = startEv || wrapEv;

  always_comb begin
    strb.loadBase     = newPhrase;
    strb.loadInterval = newPhrase || endEv;
    strb.countDown    = en && running && !intervalDone;
    nextStep          = newPhrase ? '0 : stepIdx + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running     <= 1'b0;
      shadowLen   <= STEP_W'(STEP_MIN);
      stepIdx     <= '0;
      tick        <= 1'b0;
      phraseStart <= 1'b0;
    end else begin
      running     <= en;
      tick        <= endEv;
      phraseStart <= newPhrase;
      if (newPhrase) shadowLen <= lenReq;
      if (strb.loadInterval) stepIdx <= nextStep;
    end
  end
endmodule

// File: rtl/fib_tick_gen.sv
module fib_tick_gen import fib_tick_pkg::*; #(
  parameter int BASE_W   = 8,
  parameter int STEP_MIN = 8,
  parameter int STEP_MAX = 12,
  localparam int STEP_W  = bitsFor(STEP_MAX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [BASE_W-1:0] baseCount,
  input  logic [STEP_W-1:0] phraseLen,
  output logic              tick,
  output logic [STEP_W-1:0] stepIdx,
  output logic              phraseStart
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FIB_W = bitsFor(fibTerm(STEP_MAX - 1));
  localparam int CNT_W = BASE_W + FIB_W;

  tickStrobes_t      strb;
  logic [STEP_W-1:0] nextStep;
  logic              intervalDone;

  fib_tick_ctrl #(
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX),
    .STEP_W  (STEP_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .en          (en),
    .lenIn       (phraseLen),
    .intervalDone(intervalDone),
    .strb        (strb),
    .nextStep    (nextStep),
    .stepIdx     (stepIdx),
    .tick        (tick),
    .phraseStart (phraseStart)
  );

  fib_tick_dp #(
    .BASE_W(BASE_W),
    .STEPS (STEP_MAX),
    .STEP_W(STEP_W),
    .FIB_W (FIB_W),
    .CNT_W (CNT_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .nextStep    (nextStep),
    .baseIn      (baseCount),
    .intervalDone(intervalDone)
  );
endmodule

// File: rtl/fib_tick_checker.sv
module fib_tick_checker #(
  parameter int STEP_MAX = 12,
  parameter int STEP_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              en,
  input logic              tick,
  input logic [STEP_W-1:0] stepIdx,
  input logic              phraseStart
);
  timeunit 1ns;
  timeprecision 1ps;

  p_adv_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !phraseStart) |-> (stepIdx == STEP_W'($past(stepIdx) + 1'b1)));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    phraseStart |-> (stepIdx == '0));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!tick && !phraseStart));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(stepIdx));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(en) |=> (phraseStart && stepIdx == '0));

  p_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= STEP_W'(STEP_MAX - 1));

  p_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !phraseStart) |=> !tick);
endmodule

bind fib_tick_gen fib_tick_checker #(
  .STEP_MAX(STEP_MAX),
  .STEP_W  (STEP_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .en         (en),
  .tick       (tick),
  .stepIdx    (stepIdx),
  .phraseStart(phraseStart)
);

// File: tb/fib_tick_gen_test.sv
module fib_tick_gen_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [7:0] baseCount = 8'd3;
  logic [3:0] phraseLen = 4'd8;
  logic       tick;
  logic [3:0] stepIdx;
  logic       phraseStart;

  int checks = 0;
  int failures = 0;

  // model state
  int mRun, mStep, mLen, mBase, elapsed, target;
  int mTick, mStart;

  always #2.5 clk = ~clk;

  fib_tick_gen uut (
    .clk(clk), .rstN(rstN), .en(en), .baseCount(baseCount),
    .phraseLen(phraseLen), .tick(tick), .stepIdx(stepIdx),
    .phraseStart(phraseStart)
  );

  function automatic int fibRef(input int k);
    int x = 1;
    int y = 2;
    int z;
    repeat (k) begin z = x + y; x = y; y = z; end
    return x;
  endfunction

  task automatic expectEq(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic beginPhrase();
    mBase = (baseCount == 0) ? 1 : int'(baseCount);
    mLen = (phraseLen < 8) ? 8 : (phraseLen > 12) ? 12 : int'(phraseLen);
    mStep = 0;
    elapsed = 0;
    target = mBase * fibRef(0);
    mStart = 1;
  endtask

  // behavioural reference: counts elapsed cycles upward
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mStep = 0; mLen = 8; mBase = 1; elapsed = 0; target = 0;
      mTick = 0; mStart = 0;
    end else begin
      mTick = 0;
      mStart = 0;
      if (!en) mRun = 0;
      else if (mRun == 0) begin
        mRun = 1;
        beginPhrase();
      end else begin
        elapsed++;
        if (elapsed == target) begin
          mTick = 1;
          if (mStep == mLen - 1) beginPhrase();
          else begin
            mStep++;
            elapsed = 0;
            target = mBase * fibRef(mStep);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      expectEq("R2", "tick vs model", int'(tick), mTick);
      expectEq("R4", "stepIdx vs model", int'(stepIdx), mStep);
      expectEq("R9", "phraseStart vs model", int'(phraseStart), mStart);
    end
  end

  // cycles until the next tick is seen at a falling edge
  task automatic gapToTick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick);
  endtask

  // called at the phraseStart cycle; counts ticks up to the next phrase start
  task automatic countPhrase(output int n);
    int g;
    n = 0;
    do begin
      gapToTick(g);
      n++;
    end while (!phraseStart);
  endtask

  initial begin
    int g;
    int n;
    int held;
    repeat (3) @(negedge clk);
    expectEq("R1", "tick in reset", int'(tick), 0);
    expectEq("R1", "phraseStart in reset", int'(phraseStart), 0);
    expectEq("R1", "stepIdx in reset", int'(stepIdx), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    expectEq("R8", "tick while idle", int'(tick), 0);

    en = 1'b1;
    @(negedge clk);
    expectEq("R8", "phraseStart after enable", int'(phraseStart), 1);
    expectEq("R8", "stepIdx after enable", int'(stepIdx), 0);

    // phrase A: base 3, 8 steps; new settings written mid-phrase
    for (int k = 0; k < 8; k++) begin
      gapToTick(g);
      expectEq((k > 2) ? "R6" : "R2", "gap phrase A", g, 3 * fibRef(k));
      if (k == 2) begin baseCount = 8'd5; phraseLen = 4'd10; end
    end
    expectEq("R9", "wrap marker A", int'(phraseStart), 1);
    expectEq("R4", "wrap stepIdx A", int'(stepIdx), 0);

    // phrase B: base 5, 10 steps
    for (int k = 0; k < 10; k++) begin
      gapToTick(g);
      expectEq("R2", "gap phrase B", g, 5 * fibRef(k));
      if (k == 0) begin baseCount = 8'd1; phraseLen = 4'd2; end
    end
    expectEq("R9", "wrap marker B", int'(phraseStart), 1);

    // phrase C: request 2 clamps to 8
    phraseLen = 4'd15;
    countPhrase(n);
    expectEq("R5", "ticks for short request", n, 8);

    // phrase D: request 15 clamps to 12
    phraseLen = 4'd9;
    baseCount = 8'd0;
    countPhrase(n);
    expectEq("R5", "ticks for long request", n, 12);

    // phrase E: base 0 acts as 1
    gapToTick(g);
    expectEq("R7", "first gap base 0", g, 1);
    gapToTick(g);
    expectEq("R7", "second gap base 0", g, 2);
    gapToTick(g);

    // pause mid-phrase
    held = int'(stepIdx);
    en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      expectEq("R8", "tick while paused", int'(tick), 0);
      expectEq("R8", "stepIdx while paused", int'(stepIdx), held);
    end
    baseCount = 8'd4;
    en = 1'b1;
    @(negedge clk);
    expectEq("R8", "restart marker", int'(phraseStart), 1);
    expectEq("R8", "restart stepIdx", int'(stepIdx), 0);
    gapToTick(g);
    expectEq("R8", "first gap after restart", g, 4);
    @(negedge clk);
    expectEq("R3", "tick width", int'(tick), 0);
    gapToTick(g);
    expectEq("R2", "second gap after restart", g, 4 * fibRef(1) - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule